// File: doc/BRIEF.md
# Resettable-Integrator PFC PWM Modulator

This block is the digital core of a fixed-frequency boost power-factor modulator that works on the resettable-integrator principle. Each switching period has a fixed number of clock slots. An accumulator adds the modulation value once per slot and is cleared when a period ends. The result is a sawtooth that climbs from zero to the modulation value over one period. The modulation value is the voltage-loop error word minus a fixed start offset, held between zero and a ceiling.

From the modulation value the block subtracts the sampled current-sense word times a fixed-point gain. The gate request stays high from the start of the period for as long as the sawtooth is below that difference. This gives a duty cycle of (Vm − g·Isns)/Vm without any input-voltage reference. A peak-current comparator cuts the pulse early, but it is ignored for a short blanking window after each turn-on. Once a pulse ends, it stays off until the next period begins.

The voltage-loop compensator, the averaging of the current sense and the power gate driver are outside the block. The compensator supplies `compWord`, the averaging filter supplies `isnsWord`, and `gateReq` goes to the driver.

Top module: `occ_pwm_mod`

## Requirements
- R1: A period lasts PERIOD_CNT clock cycles (default 50). `periodStart` is high in slot 0 of every period and in no other slot.
- R2: Vm = compWord − VM_OFFSET, or 0 when compWord ≤ VM_OFFSET, limited to VM_MAX (defaults 200 and 1000). It is captured in the final slot of a period and applies unchanged for the whole next period. Vm is 0 after reset.
- R3: With no trip, the pulse of a period covers the decisions in slots k for which Vm·k < S·PERIOD_CNT, where S = Vm − G. The pulse is contiguous from slot 0, so its width is min(PERIOD_CNT, ceil(S·PERIOD_CNT/Vm)).
- R4: The scaled current G = floor(isnsWord·GAIN_DC / 2^GAIN_FRAC), saturated to the all-ones value of DATA_W bits (defaults GAIN_DC 24, GAIN_FRAC 4, DATA_W 12, so the gain is 1.5).
- R5: When S ≤ 0, which includes Vm = 0, the period produces no pulse.
- R6: If isnsWord > PEAK_THR (default 400) in a slot at or after the blanking window, the gate is low on the next cycle. A value equal to PEAK_THR does not trip.
- R7: In slots 0 to BLANK_CNT−1 (default 5) the peak comparison is ignored.
- R8: A pulse that has ended, whether by the ramp or by a trip, cannot restart before the next period. `gateReq` rises only in the cycle after slot 0.
- R9: During reset `gateReq` is low and `periodStart` is high.
- R10: `gateReq` shows the decision made in each slot one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| compWord | input | DATA_W | Voltage-loop error word, unsigned |
| isnsWord | input | DATA_W | Averaged current-sense magnitude, unsigned |
| gateReq | output | 1 | Gate request, registered |
| periodStart | output | 1 | High in the first slot of each period |

## Verification
The bench aims at the edges of the duty formula. It uses a summer exactly at zero, a Vm of one count, a compare word just below and just above the offset, and a gain product whose fraction separates truncation from rounding. A design that rounded the gain, or compared with ≤ instead of <, would be off by one slot in the pulse width. It also drives the sense word exactly at and one above the trip level. It checks that a trip inside the blanking window is deferred until the window ends, so an unblanked or inverted comparator shows up as the wrong width. Two further tests change the error word in mid-period and drop the current after a trip. A design that tracked Vm live, or let the pulse restart after a trip, would show a changed width or a second pulse.

// File: rtl/occ_pwm_pkg.sv
package occ_pwm_pkg;

  // strobes from the slot sequencer to the datapath
  typedef struct packed {
    logic periodEnd;  // final slot of the switching period
    logic blankOn;    // slot lies inside the leading-edge blanking window
  } slotStrobe_t;

endpackage

// File: rtl/occ_pwm_ctrl.sv
module occ_pwm_ctrl
  import occ_pwm_pkg::*;
#(
  parameter int PERIOD_CNT = 50,
  parameter int BLANK_CNT  = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  output slotStrobe_t strobe,
  output logic        periodStart
);

  localparam int CNT_W = (PERIOD_CNT > 2) ? $clog2(PERIOD_CNT) : 1;
  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(PERIOD_CNT - 1);

  logic [CNT_W-1:0] slot;

  always_ff @(posedge clk) begin
    if (!rst_n)                slot <= '0;
    else if (strobe.periodEnd) slot <= '0;
    else                       slot <= slot + 1'b1;
  end

  assign strobe.periodEnd = (slot == LAST_SLOT);
  assign periodStart      = (slot == '0);

  generate
    if (BLANK_CNT <= 0) begin : gNoBlank
      assign strobe.blankOn = 1'b0;
    end else if (BLANK_CNT >= PERIOD_CNT) begin : gFullBlank
      assign strobe.blankOn = 1'b1;
    end else begin : gBlank
      localparam logic [CNT_W-1:0] BLANK_END = CNT_W'(BLANK_CNT);
      assign strobe.blankOn = (slot < BLANK_END);
    end
  endgenerate

endmodule

// File: rtl/occ_pwm_dp.sv
module occ_pwm_dp
  import occ_pwm_pkg::*;
#(
  parameter int DATA_W     = 12,
  parameter int PERIOD_CNT = 50,
  parameter int VM_OFFSET  = 200,
  parameter int VM_MAX     = 1000,
  parameter int GAIN_W     = 8,
  parameter int GAIN_FRAC  = 4,
  parameter int GAIN_DC    = 24,
  parameter int PEAK_THR   = 400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] compWord,
  input  logic [DATA_W-1:0] isnsWord,
  input  slotStrobe_t       strobe,
  output logic              gateReq,
  output logic [DATA_W-1:0] vmHeld
);

  localparam int CNT_W  = $clog2(PERIOD_CNT + 1);
  localparam int ACC_W  = DATA_W + CNT_W;
  localparam int PROD_W = DATA_W + GAIN_W;
  localparam logic [DATA_W-1:0] OFFSET_V = DATA_W'(VM_OFFSET);
  localparam logic [DATA_W-1:0] MAX_V    = DATA_W'(VM_MAX);
  localparam logic [DATA_W-1:0] THR_V    = DATA_W'(PEAK_THR);
  localparam logic [PROD_W-1:0] SAT_V    = PROD_W'({DATA_W{1'b1}});

  logic [DATA_W-1:0]        vmRaw, vmNow, gainSat;
  logic [PROD_W-1:0]        gainFull, gainShift;
  logic signed [DATA_W:0]   summer;
  logic                     summerPos, peakOver, gateNext, latchOff;
  logic [ACC_W-1:0]         rampAcc, target;

  // modulation value: offset removed, floored at zero, ceiling applied
  always_comb begin
    if (compWord > OFFSET_V) vmRaw = compWord - OFFSET_V;
    else                     vmRaw = '0;
    vmNow = (vmRaw > MAX_V) ? MAX_V : vmRaw;
  end

  // fixed-point current gain with saturation
  always_comb begin
    gainFull  = PROD_W'(isnsWord) * PROD_W'(GAIN_DC);
    gainShift = gainFull >> GAIN_FRAC;
    gainSat   = (gainShift > SAT_V) ? {DATA_W{1'b1}} : gainShift[DATA_W-1:0];
  end

  // summer and scaled threshold for the ramp comparison
  always_comb begin
    summer    = $signed({1'b0, vmHeld}) - $signed({1'b0, gainSat});
    summerPos = !summer[DATA_W] && (summer != '0);
    target    = ACC_W'(summer[DATA_W-1:0]) * ACC_W'(PERIOD_CNT);
    peakOver  = (isnsWord > THR_V);
    gateNext  = !latchOff && summerPos && (rampAcc < target)
                && !(peakOver && !strobe.blankOn);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vmHeld   <= '0;
      rampAcc  <= '0;
      latchOff <= 1'b0;
      gateReq  <= 1'b0;
    end else begin
      gateReq <= gateNext;
      if (strobe.periodEnd) begin
        vmHeld   <= vmNow;
        rampAcc  <= '0;
        latchOff <= 1'b0;
      end else begin
        rampAcc  <= rampAcc + ACC_W'(vmHeld);
        latchOff <= latchOff | !gateNext;
      end
    end
  end

endmodule

// File: rtl/occ_pwm_mod.sv
module occ_pwm_mod
  import occ_pwm_pkg::*;
#(
  parameter int DATA_W     = 12,
  parameter int PERIOD_CNT = 50,
  parameter int BLANK_CNT  = 5,
  parameter int VM_OFFSET  = 200,
  parameter int VM_MAX     = 1000,
  parameter int GAIN_W     = 8,
  parameter int GAIN_FRAC  = 4,
  parameter int GAIN_DC    = 24,
  parameter int PEAK_THR   = 400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] compWord,
  input  logic [DATA_W-1:0] isnsWord,
  output logic              gateReq,
  output logic              periodStart
);

  slotStrobe_t       strobe;
  logic [DATA_W-1:0] vmHeld;

  occ_pwm_ctrl #(
    .PERIOD_CNT(PERIOD_CNT),
    .BLANK_CNT (BLANK_CNT)
  ) uCtrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .periodStart(periodStart)
  );

  occ_pwm_dp #(
    .DATA_W    (DATA_W),
    .PERIOD_CNT(PERIOD_CNT),
    .VM_OFFSET (VM_OFFSET),
    .VM_MAX    (VM_MAX),
    .GAIN_W    (GAIN_W),
    .GAIN_FRAC (GAIN_FRAC),
    .GAIN_DC   (GAIN_DC),
    .PEAK_THR  (PEAK_THR)
  ) uDp (
    .clk     (clk),
    .rst_n   (rst_n),
    .compWord(compWord),
    .isnsWord(isnsWord),
    .strobe  (strobe),
    .gateReq (gateReq),
    .vmHeld  (vmHeld)
  );

endmodule

// File: rtl/occ_pwm_mod_chk.sv
module occ_pwm_mod_chk #(
  parameter int DATA_W     = 12,
  parameter int PERIOD_CNT = 50,
  parameter int BLANK_CNT  = 5,
  parameter int PEAK_THR   = 400
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] isnsWord,
  input logic              gateReq,
  input logic              periodStart,
  input logic [DATA_W-1:0] vmHeld
);

  int slotCnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                         slotCnt <= 0;
    else if (slotCnt == PERIOD_CNT - 1) slotCnt <= 0;
    else                                slotCnt <= slotCnt + 1;
  end

  AST_PERIOD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    periodStart == (slotCnt == 0)); // R1

  AST_RISE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gateReq) |-> (slotCnt == 1)); // R8

  AST_PEAK_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    ((int'(isnsWord) > PEAK_THR) && (slotCnt >= BLANK_CNT)) |=> !gateReq); // R6

  AST_ZERO_VM: assert property (@(posedge clk) disable iff (!rst_n)
    (vmHeld == '0) |=> !gateReq); // R5

endmodule

bind occ_pwm_mod occ_pwm_mod_chk #(
  .DATA_W    (DATA_W),
  .PERIOD_CNT(PERIOD_CNT),
  .BLANK_CNT (BLANK_CNT),
  .PEAK_THR  (PEAK_THR)
) uChk (
  .clk        (clk),
  .rst_n      (rst_n),
  .isnsWord   (isnsWord),
  .gateReq    (gateReq),
  .periodStart(periodStart),
  .vmHeld     (vmHeld)
);

// File: tb/occ_pwm_mod_test.sv
module occ_pwm_mod_test;

  localparam int P  = 50;
  localparam int NV = 12;

  // stimulus: compare word, sense word, expected pulse width in slots
  localparam int VEC_COMP [NV] = '{1200, 1200, 700, 600, 150, 2000, 1200, 800, 201, 1200, 300, 200};
  localparam int VEC_ISNS [NV] = '{   0,  200, 100, 101,   0,  400,  401, 400,   0, 4095,  33,   0};
  localparam int VEC_EXP  [NV] = '{  50,   35,  35,  32,   0,   20,    5,   0,  50,    0,  26,   0};
  localparam string VEC_REQ [NV] = '{"R3", "R3", "R3", "R3", "R2", "R2", "R7", "R5", "R2", "R4", "R4", "R5"};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] compWord = '0;
  logic [11:0] isnsWord = '0;
  logic        gateReq, periodStart;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  occ_pwm_mod uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .compWord   (compWord),
    .isnsWord   (isnsWord),
    .gateReq    (gateReq),
    .periodStart(periodStart)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitStart();
    do @(negedge clk); while (!periodStart);
  endtask

  // counts the gate over slots 1..P, i.e. the pulse decided in one period
  task automatic measure(output int n);
    n = 0;
    repeat (P) begin
      @(negedge clk);
      n += int'(gateReq);
    end
  endtask

  initial begin
    int width, gap;
    repeat (3) @(negedge clk);
    check("R9 gate in reset", int'(gateReq), 0);
    check("R9 slot in reset", int'(periodStart), 1);
    rst_n = 1'b1;

    // R1: spacing of period starts
    waitStart();
    gap = 0;
    do begin @(negedge clk); gap++; end while (!periodStart);
    check("R1 period length", gap, P);

    // R5: Vm is zero for the first period after reset
    compWord = 12'd1200;
    measure(width);
    check("R5 zero Vm after reset", width, 0);

    for (int i = 0; i < NV; i++) begin
      compWord = 12'(VEC_COMP[i]);
      isnsWord = 12'(VEC_ISNS[i]);
      waitStart();
      waitStart();
      measure(width);
      check(VEC_REQ[i], width, VEC_EXP[i]);
    end

    // R2: a mid-period change of the error word waits for the next period
    compWord = 12'd1200;
    isnsWord = 12'd200;
    waitStart();
    waitStart();
    compWord = 12'd700;
    measure(width);
    check("R2 Vm held in period", width, 35);
    measure(width);
    check("R2 Vm taken next period", width, 20);

    // R8, R10: a tripped pulse stays off after the current drops
    compWord = 12'd1200;
    isnsWord = 12'd401;
    waitStart();
    waitStart();
    width = 0;
    repeat (10) begin @(negedge clk); width += int'(gateReq); end
    check("R6 trip after blanking", width, 5);
    isnsWord = 12'd0;
    width = 0;
    repeat (P - 10) begin @(negedge clk); width += int'(gateReq); end
    check("R8 no restart in period", width, 0);
    @(negedge clk);
    check("R10 gate one clock after slot 0", int'(gateReq), 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule